// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block selects one interrupt among a set of sources and decides whether it may interrupt the CPU. Each source has an 8-bit control word. The word holds a pending flag, an enable bit, a 4-bit priority level and a 2-bit group level. Software reads and writes these words through a small register port. A hardware pulse on a source's set line marks that source as pending.

The CPU strobes `insn_end` once per instruction boundary. On that cycle the block compares all sources that are both pending and enabled. The highest priority level wins. On equal levels the higher group level wins. On a full tie the lowest index wins. The winner's index and level are registered and then held until the next strobe. An interrupt request is raised only when two conditions are met: the global enable input is set, and the winner's level is strictly above the CPU's current level.

When the CPU acknowledges, it loads the reported level as its new priority. The block then clears that source's pending flag and drops the request.

Top module: `irq_arbiter`

## Requirements
- R1: Each control word reads back exactly as it was last written. The bit layout is bit 7 = pending flag, bit 6 = enable, bits 5:2 = priority level, bits 1:0 = group level.
- R2: Bits 15:8 of `reg_rdata` always read zero. Bits 15:8 of `reg_wdata` are discarded.
- R3: Among sources that are both pending and enabled, the source with the highest priority level is reported.
- R4: Among such sources on the same priority level, the source with the higher group level is reported.
- R5: When the priority level and the group level are both equal, the source with the lower index is reported.
- R6: A source whose pending flag is clear, or whose enable bit is clear, never wins.
- R7: `irq_idx`, `irq_lvl` and `irq` change only on the cycle after `insn_end` or `irq_ack`; otherwise they hold. When no source is eligible, the strobe reports index 0 and level 0.
- R8: `irq` is raised after a strobe only if `gie` was set and the winner's level was strictly greater than `cpu_lvl`. A winner at level 0 therefore never raises `irq`.
- R9: An `irq_ack` pulse clears the pending flag of the source currently shown on `irq_idx`, and `irq` is low on the next cycle. If `insn_end` arrives in the same cycle, the acknowledge still takes precedence.
- R10: A `src_set` pulse in the same cycle as a software write to that source leaves the pending flag set. The other fields take the written values.
- R11: After reset, every control word reads 00h and `irq`, `irq_idx` and `irq_lvl` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control word at `reg_addr` |
| reg_addr | input | 3 | Control word select (source index) |
| reg_wdata | input | 16 | Write data; only bits 7:0 are used |
| reg_rdata | output | 16 | Control word at `reg_addr`, zero-extended |
| src_set | input | 8 | Per-source hardware pulse that sets the pending flag |
| insn_end | input | 1 | Instruction boundary strobe; latches the arbitration result |
| gie | input | 1 | Global interrupt enable |
| cpu_lvl | input | 4 | Current CPU priority level |
| irq_ack | input | 1 | CPU acknowledge of the reported request |
| irq | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 3 | Winning source index |
| irq_lvl | output | 4 | Winning source priority level |

## Verification
Directed patterns separate the stages of the priority decision:
- a higher level against a lower level;
- a higher group on an equal level;
- a full tie between two indices;
- a high-level source that is pending but disabled.

Each pattern shows whether the comparison looks at the right field and resolves it in the right direction. Further directed steps cover the global enable and the strict level comparison, including an equal CPU level. They also cover an acknowledge that coincides with a strobe, and a hardware set that coincides with a software clear. A long constrained-random run mixes these conditions with register writes and held-output cycles. It compares every cycle against a bench model that is built from the requirements.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter int GRP_W = 2,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int KEY_W = LVL_W + GRP_W,
  localparam int CTL_W = KEY_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic [N_SRC-1:0] src_set,
  input  logic             insn_end,
  input  logic             gie,
  input  logic [LVL_W-1:0] cpu_lvl,
  input  logic             irq_ack,
  output logic             irq,
  output logic [IDX_W-1:0] irq_idx,
  output logic [LVL_W-1:0] irq_lvl
);
  localparam int FLAG = CTL_W - 1;
  localparam int ENB  = CTL_W - 2;

  logic [N_SRC-1:0][CTL_W-1:0] ctl;
  logic             found;
  logic [KEY_W-1:0] best_key;
  logic [IDX_W-1:0] best_idx;
  logic [LVL_W-1:0] best_lvl;

  assign reg_rdata = (int'(reg_addr) < N_SRC) ? 16'(ctl[reg_addr]) : 16'h0000;
  assign best_lvl  = best_key[KEY_W-1:GRP_W];

  always_comb begin
    found    = 1'b0;
    best_key = '0;
    best_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (ctl[i][FLAG] && ctl[i][ENB] && (!found || ctl[i][KEY_W-1:0] > best_key)) begin
        found    = 1'b1;
        best_key = ctl[i][KEY_W-1:0];
        best_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (irq_ack && irq_idx == IDX_W'(i)) ctl[i][FLAG] <= 1'b0;
        if (reg_we && reg_addr == IDX_W'(i)) ctl[i] <= reg_wdata[CTL_W-1:0];
        if (src_set[i]) ctl[i][FLAG] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      irq_idx <= '0;
      irq_lvl <= '0;
    end else begin
      if (insn_end) begin
        irq_idx <= best_idx;
        irq_lvl <= best_lvl;
      end
      if (irq_ack)       irq <= 1'b0;
      else if (insn_end) irq <= found && gie && (best_lvl > cpu_lvl);
    end
  end
endmodule

module irq_arbiter_chk #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter int GRP_W = 2,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_end,
  input logic             gie,
  input logic [LVL_W-1:0] cpu_lvl,
  input logic             irq_ack,
  input logic             irq,
  input logic [IDX_W-1:0] irq_idx,
  input logic [LVL_W-1:0] irq_lvl
);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(gie) && $past(insn_end) && irq_lvl > $past(cpu_lvl)));

  // R8
  lvl_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_lvl != '0);

  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_end && !irq_ack) |=> ($stable(irq_idx) && $stable(irq_lvl) && $stable(irq)));

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!irq && irq_idx == '0 && irq_lvl == '0);
    end
  end
endmodule

bind irq_arbiter irq_arbiter_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W), .GRP_W(GRP_W)) u_chk (.*);

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  src_set = '0;
  logic        insn_end = 1'b0;
  logic        gie = 1'b0;
  logic [3:0]  cpu_lvl = '0;
  logic        irq_ack = 1'b0;
  logic        irq;
  logic [2:0]  irq_idx;
  logic [3:0]  irq_lvl;

  int checks = 0;
  int failures = 0;

  logic [7:0] m_ctl [8];
  logic       e_irq;
  logic [2:0] e_idx;
  logic [3:0] e_lvl;

  always #10 clk = ~clk;

  irq_arbiter u0 (.*);

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [8:0] pick();
    logic       f = 1'b0;
    logic [5:0] k = '0;
    logic [2:0] ix = '0;
    for (int i = 0; i < 8; i++)
      if (m_ctl[i][7] && m_ctl[i][6] && (!f || m_ctl[i][5:0] > k)) begin
        f = 1'b1; k = m_ctl[i][5:0]; ix = 3'(i);
      end
    return {f, ix, k[5:2], 1'b0};
  endfunction

  task automatic tick(input string tag);
    logic [7:0] n_ctl [8];
    logic [8:0] p;
    logic       n_irq;
    logic [2:0] n_idx;
    logic [3:0] n_lvl;
    p = pick();
    n_ctl = m_ctl;
    for (int i = 0; i < 8; i++) begin
      if (irq_ack && e_idx == 3'(i)) n_ctl[i][7] = 1'b0;
      if (reg_we && reg_addr == 3'(i)) n_ctl[i] = reg_wdata[7:0];
      if (src_set[i]) n_ctl[i][7] = 1'b1;
    end
    n_irq = e_irq; n_idx = e_idx; n_lvl = e_lvl;
    if (insn_end) begin n_idx = p[7:5]; n_lvl = p[4:1]; end
    if (irq_ack) n_irq = 1'b0;
    else if (insn_end) n_irq = p[8] && gie && (p[4:1] > cpu_lvl);
    @(posedge clk);
    @(negedge clk);
    m_ctl = n_ctl; e_irq = n_irq; e_idx = n_idx; e_lvl = n_lvl;
    reg_we = 1'b0; src_set = '0; insn_end = 1'b0; irq_ack = 1'b0;
    chk(tag, "irq", 16'(irq), 16'(e_irq));
    chk(tag, "irq_idx", 16'(irq_idx), 16'(e_idx));
    chk(tag, "irq_lvl", 16'(irq_lvl), 16'(e_lvl));
    chk(tag, "reg_rdata", reg_rdata, {8'h00, m_ctl[reg_addr]});
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(tag);
  endtask

  task automatic strobe(input string tag);
    insn_end = 1'b1;
    tick(tag);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) m_ctl[i] = 8'h00;
    e_irq = 1'b0; e_idx = '0; e_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    for (int i = 0; i < 8; i++) begin
      reg_addr = 3'(i); #1;
      chk("R11", "reg_rdata", reg_rdata, 16'h0000);
    end
    chk("R11", "irq", 16'(irq), 16'h0);
    // R1 R2 layout and upper byte discard
    wr(3'd3, 16'hABCD, "R1 R2");
    wr(3'd3, 16'h0000, "R1");
    gie = 1'b1; cpu_lvl = 4'd0;
    // R3 level 9 beats level 5
    wr(3'd1, 16'h00D4, "R3");
    wr(3'd6, 16'h00E4, "R3");
    strobe("R3");
    chk("R3", "winner", 16'(irq_idx), 16'd6);
    // R4 higher group on same level
    wr(3'd2, 16'h00E7, "R4");
    strobe("R4");
    chk("R4", "winner", 16'(irq_idx), 16'd2);
    // R5 full tie, lower index
    wr(3'd5, 16'h00E7, "R5");
    strobe("R5");
    chk("R5", "winner", 16'(irq_idx), 16'd2);
    // R6 pending but disabled level 15
    wr(3'd0, 16'h00BC, "R6");
    strobe("R6");
    chk("R6", "winner", 16'(irq_idx), 16'd2);
    // R7 hold without strobe
    wr(3'd7, 16'h00FF, "R7");
    tick("R7");
    chk("R7", "held", 16'(irq_idx), 16'd2);
    // R8 strict comparison and global enable
    cpu_lvl = 4'd15; strobe("R8");
    chk("R8", "irq equal level", 16'(irq), 16'h0);
    wr(3'd7, 16'h0000, "R8");
    cpu_lvl = 4'd9; strobe("R8");
    chk("R8", "irq equal level", 16'(irq), 16'h0);
    cpu_lvl = 4'd8; gie = 1'b0; strobe("R8");
    chk("R8", "irq no gie", 16'(irq), 16'h0);
    gie = 1'b1; strobe("R8");
    chk("R8", "irq", 16'(irq), 16'h1);
    // R9 acknowledge with simultaneous strobe
    irq_ack = 1'b1; insn_end = 1'b1; reg_addr = 3'd2;
    tick("R9");
    chk("R9", "irq", 16'(irq), 16'h0);
    chk("R9", "flag cleared", reg_rdata, 16'h0067);
    // R10 hardware set beats software clear
    src_set = 8'h10;
    wr(3'd4, 16'h0000, "R10");
    chk("R10", "flag", reg_rdata, 16'h0080);
    // R8 level 0 winner never interrupts
    for (int i = 0; i < 8; i++) wr(3'(i), 16'h0000, "R8");
    wr(3'd3, 16'h00C3, "R8");
    cpu_lvl = 4'd0; strobe("R8");
    chk("R8", "level0 irq", 16'(irq), 16'h0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      reg_we = ($urandom_range(0, 3) == 0);
      reg_addr = 3'($urandom_range(0, 7));
      reg_wdata = 16'($urandom);
      src_set = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      insn_end = ($urandom_range(0, 2) != 0);
      gie = ($urandom_range(0, 4) != 0);
      cpu_lvl = 4'($urandom_range(0, 12));
      irq_ack = e_irq && ($urandom_range(0, 1) == 0);
      tick("R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule